// File: doc/BRIEF.md
# Slot Interrupt Line Router

This block takes interrupt events raised by devices on an expansion bus, each identified by the slot it sits in and the pin (A to D, encoded 0 to 3) it uses, and turns them into a single interrupt wire towards the processor. A fixed routing table first converts the slot and pin pair into an internal interrupt number. Numbers from 32 up belong to the block's own interrupt lines: line index = number minus 32.

Two 32-bit configuration masks, indexed by that line index, decide how an event drives the processor wire. When the line's edge-select bit is set, the event produces a single-cycle high pulse. When it is clear, the line is level-driven and the wire is set to the line's polarity bit. In both cases the level carried by the event itself is not used. The last level-driven value is held between events, and a pulse falls back to it after one cycle. Events whose number lies outside the internal range leave the held level alone.

Top module: `irq_line_router`

## Requirements
- R1: While reset is asserted and in the cycle after it, `cpu_irq` is 0 and `irq_num` is 0.
- R2: For slot 5, pin p (0..3) maps to internal number 32 + p.
- R3: Slot 6 maps to 36 and slot 7 maps to 37, for every pin value.
- R4: For slots 8 through 12, pin p maps to 38 + (slot - 8) + p.
- R5: Every slot not named in R2 to R4 maps to the pin number itself (0..3).
- R6: `irq_num` shows the mapped number of an event from the clock edge that samples `evt_valid` high and keeps it until the next event.
- R7: If the line index (number minus 32, in 0..31) has its bit set in `edge_sel`, `cpu_irq` is 1 for exactly the cycle after the event, whatever `evt_level` is.
- R8: If the line's `edge_sel` bit is clear, the held level becomes that line's `pol_sel` bit from the cycle after the event; `evt_level` has no effect.
- R9: In a cycle after which no event was sampled, `cpu_irq` equals the held level (0 after reset), so a pulse lasts one cycle and a level persists.
- R10: An event whose number lies outside 32..63 leaves the held level unchanged and raises no pulse, though `irq_num` still updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_valid | input | 1 | An interrupt event is presented this cycle |
| evt_slot | input | 5 | Slot number of the raising device |
| evt_pin | input | 2 | Pin of the raising device, 0 = A to 3 = D |
| evt_level | input | 1 | Level carried by the event (not used for the drive) |
| edge_sel | input | 32 | Per-line edge select, bit i for line index i |
| pol_sel | input | 32 | Per-line polarity for level-driven lines |
| irq_num | output | 8 | Mapped interrupt number of the last event |
| cpu_irq | output | 1 | Interrupt wire to the processor |

## Verification
The bench builds the router with its default parameters: an internal base of 32 and 32 lines, so the full mask width is covered and every slot class of the routing table reaches a distinct line. With these values the highest mapped number (slot 12, pin 3 gives 45) stays inside the internal range, while slots outside 5..12 yield pass-through numbers 0..3 that fall below it, which exercises the ignored-event path. Random masks that change every cycle make edge and level lines alternate on the same index, reaching pulse-over-high, back-to-back pulses and level overwrites.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned SLOT_W     = 5;
    localparam int unsigned PIN_W      = 2;
    localparam int unsigned NUM_W      = 8;
    localparam int unsigned LINE_BASE  = 32;
    localparam int unsigned LINE_CNT   = 32;
    localparam int unsigned IDX_W      = $clog2(LINE_CNT);

    // routing table slot classes
    localparam int unsigned SHARED_SLOT    = 5;
    localparam int unsigned GFX_SLOT       = 6;
    localparam int unsigned GFX_OFS        = 4;
    localparam int unsigned NIC_SLOT       = 7;
    localparam int unsigned NIC_OFS        = 5;
    localparam int unsigned OPEN_FIRST     = 8;
    localparam int unsigned OPEN_LAST      = 12;
    localparam int unsigned OPEN_OFS       = 6;

    typedef logic [NUM_W-1:0] irq_num_t;

    typedef enum logic [2:0] {
        CLS_SHARED,
        CLS_GFX,
        CLS_NIC,
        CLS_OPEN,
        CLS_PASS
    } slot_class_e;

    typedef struct packed {
        irq_num_t           num;
        logic               hit;
        logic [IDX_W-1:0]   idx;
    } route_t;

    typedef struct packed {
        logic held;
        logic pulse;
    } drive_state_t;

    function automatic slot_class_e classify(input logic [SLOT_W-1:0] slot);
        slot_class_e c;
        if (slot == SLOT_W'(SHARED_SLOT))
            c = CLS_SHARED;
        else if (slot == SLOT_W'(GFX_SLOT))
            c = CLS_GFX;
        else if (slot == SLOT_W'(NIC_SLOT))
            c = CLS_NIC;
        else if (slot >= SLOT_W'(OPEN_FIRST) && slot <= SLOT_W'(OPEN_LAST))
            c = CLS_OPEN;
        else
            c = CLS_PASS;
        return c;
    endfunction

endpackage

// File: rtl/irq_route_map.sv
module irq_route_map
    import irq_route_pkg::*;
#(
    parameter int unsigned BASE  = LINE_BASE,
    parameter int unsigned LINES = LINE_CNT
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [PIN_W-1:0]  pin,
    output route_t            route
);
    localparam irq_num_t BASE_N = irq_num_t'(BASE);
    localparam irq_num_t TOP_N  = irq_num_t'(BASE + LINES - 1);

    slot_class_e cls;
    irq_num_t    num;
    irq_num_t    rel;
    irq_num_t    pin_n;

    assign pin_n = irq_num_t'(pin);

    always_comb begin
        cls = classify(slot);
        unique case (cls)
            CLS_SHARED: num = BASE_N + pin_n;
            CLS_GFX:    num = BASE_N + irq_num_t'(GFX_OFS);
            CLS_NIC:    num = BASE_N + irq_num_t'(NIC_OFS);
            CLS_OPEN:   num = BASE_N + irq_num_t'(OPEN_OFS)
                              + (irq_num_t'(slot) - irq_num_t'(OPEN_FIRST)) + pin_n;
            default:    num = pin_n;
        endcase
    end

    assign rel       = num - BASE_N;
    assign route.num = num;
    assign route.hit = (num >= BASE_N) && (num <= TOP_N);
    assign route.idx = rel[IDX_W-1:0];

endmodule

// File: rtl/irq_line_select.sv
module irq_line_select
    import irq_route_pkg::*;
#(
    parameter int unsigned LINES = LINE_CNT
) (
    input  route_t             route,
    input  logic [LINES-1:0]   edge_sel,
    input  logic [LINES-1:0]   pol_sel,
    output logic               edge_line,
    output logic               pol_line
);
    logic [LINES-1:0] onehot;

    for (genvar i = 0; i < LINES; i++) begin : g_dec
        assign onehot[i] = route.hit && (route.idx == IDX_W'(i));
    end

    assign edge_line = |(onehot & edge_sel);
    assign pol_line  = |(onehot & pol_sel);

endmodule

// File: rtl/irq_out_drive.sv
module irq_out_drive
    import irq_route_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     evt_valid,
    input  route_t   route,
    input  logic     edge_line,
    input  logic     pol_line,
    output irq_num_t num_q,
    output logic     held_q,
    output logic     cpu_irq
);
    drive_state_t st_q, st_d;
    irq_num_t     num_d;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        num_d      = num_q;
        if (evt_valid) begin
            num_d = route.num;
            if (route.hit) begin
                if (edge_line)
                    st_d.pulse = 1'b1;
                else
                    st_d.held = pol_line;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            num_q <= '0;
        end else begin
            st_q  <= st_d;
            num_q <= num_d;
        end
    end

    assign held_q  = st_q.held;
    assign cpu_irq = st_q.held | st_q.pulse;

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
    import irq_route_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                evt_valid,
    input  logic [SLOT_W-1:0]   evt_slot,
    input  logic [PIN_W-1:0]    evt_pin,
    input  logic                evt_level,
    input  logic [LINE_CNT-1:0] edge_sel,
    input  logic [LINE_CNT-1:0] pol_sel,
    output logic [NUM_W-1:0]    irq_num,
    output logic                cpu_irq
);
    route_t route_w;
    logic   edge_w;
    logic   pol_w;
    logic   held_w;
    logic   level_unused;

    assign level_unused = evt_level;

    irq_route_map #(
        .BASE  (LINE_BASE),
        .LINES (LINE_CNT)
    ) u_map (
        .slot  (evt_slot),
        .pin   (evt_pin),
        .route (route_w)
    );

    irq_line_select #(
        .LINES (LINE_CNT)
    ) u_sel (
        .route     (route_w),
        .edge_sel  (edge_sel),
        .pol_sel   (pol_sel),
        .edge_line (edge_w),
        .pol_line  (pol_w)
    );

    irq_out_drive u_drv (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .route     (route_w),
        .edge_line (edge_w),
        .pol_line  (pol_w),
        .num_q     (irq_num),
        .held_q    (held_w),
        .cpu_irq   (cpu_irq)
    );

endmodule

// File: rtl/irq_line_router_chk.sv
module irq_line_router_chk
    import irq_route_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                evt_valid,
    input logic [SLOT_W-1:0]   evt_slot,
    input logic [LINE_CNT-1:0] edge_sel,
    input logic [LINE_CNT-1:0] pol_sel,
    input route_t              route,
    input logic                held,
    input logic [NUM_W-1:0]    irq_num,
    input logic                cpu_irq
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (!cpu_irq && irq_num == '0));

    // R3
    gfx_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_slot == SLOT_W'(GFX_SLOT)) |=> irq_num == NUM_W'(LINE_BASE + GFX_OFS));

    // R6
    num_capture_chk: assert property (@(posedge clk) disable iff (rst)
        evt_valid |=> irq_num == $past(route.num));

    // R7
    edge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && route.hit && edge_sel[route.idx]) |=> cpu_irq);

    // R8
    level_pol_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && route.hit && !edge_sel[route.idx]) |=> cpu_irq == $past(pol_sel[route.idx]));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !evt_valid |=> (cpu_irq == held && $stable(held)));

    // R10
    miss_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !route.hit) |=> (cpu_irq == held && $stable(held)));

endmodule

bind irq_line_router irq_line_router_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (evt_valid),
    .evt_slot  (evt_slot),
    .edge_sel  (edge_sel),
    .pol_sel   (pol_sel),
    .route     (route_w),
    .held      (held_w),
    .irq_num   (irq_num),
    .cpu_irq   (cpu_irq)
);

// File: tb/sim_irq_line_router.sv
`timescale 1ns/1ps
module sim_irq_line_router;
    logic        clk = 1'b0;
    logic        rst;
    logic        evt_valid;
    logic [4:0]  evt_slot;
    logic [1:0]  evt_pin;
    logic        evt_level;
    logic [31:0] edge_sel;
    logic [31:0] pol_sel;
    logic [7:0]  irq_num;
    logic        cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int exp_num = 0;
    bit exp_held = 0;
    bit exp_pulse = 0;

    always #2 clk = ~clk;

    irq_line_router u0 (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_slot(evt_slot),
        .evt_pin(evt_pin), .evt_level(evt_level), .edge_sel(edge_sel),
        .pol_sel(pol_sel), .irq_num(irq_num), .cpu_irq(cpu_irq)
    );

    function automatic int map_ref(input int slot, input int pin);
        if (slot == 5) return 32 + (pin % 4);
        if (slot == 6) return 36;
        if (slot == 7) return 37;
        if (slot >= 8 && slot <= 12) return 38 + (slot - 8) + pin;
        return pin;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input int slot, input int pin, input bit lvl,
                        input logic [31:0] em, input logic [31:0] pm, input string req);
        int n;
        @(negedge clk);
        evt_valid = v; evt_slot = 5'(slot); evt_pin = 2'(pin);
        evt_level = lvl; edge_sel = em; pol_sel = pm;
        @(posedge clk);
        #1;
        exp_pulse = 0;
        if (v) begin
            n = map_ref(slot, pin);
            exp_num = n;
            if (n >= 32 && n <= 63) begin
                if (em[n-32]) exp_pulse = 1;
                else exp_held = pm[n-32];
            end
        end
        check(irq_num == 8'(exp_num), req, int'(irq_num), exp_num);
        check(cpu_irq == (exp_held | exp_pulse), req, int'(cpu_irq), int'(exp_held | exp_pulse));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        rst = 1; evt_valid = 0; evt_slot = 0; evt_pin = 0; evt_level = 0;
        edge_sel = 0; pol_sel = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1
        check(cpu_irq == 0, "R1", int'(cpu_irq), 0);
        check(irq_num == 0, "R1", int'(irq_num), 0);
        @(negedge clk); rst = 0;

        // R2 shared slot, level high
        step(1, 5, 2, 0, 32'h0, 32'h0000_0004, "R2");
        // R8 level low ignores evt_level=1
        step(1, 5, 2, 1, 32'h0, 32'h0, "R8");
        // R3 pins are ignored on slots 6 and 7
        step(1, 6, 3, 0, 32'h0, 32'h0000_0010, "R3");
        step(1, 7, 1, 0, 32'h0, 32'h0, "R3");
        // R4 upper slot corner
        step(1, 12, 3, 0, 32'h0, 32'h0000_2000, "R4");
        step(1, 8, 0, 0, 32'h0, 32'h0, "R4");
        // R7 edge pulse with evt_level 0, then R9 return
        step(1, 9, 1, 0, 32'h0000_0100, 32'h0, "R7");
        step(0, 0, 0, 0, 32'h0, 32'h0, "R9");
        // raise held level, then R5/R10 passthrough keeps it
        step(1, 5, 0, 0, 32'h0, 32'h1, "R8");
        step(1, 0, 2, 1, 32'hFFFF_FFFF, 32'h0, "R5");
        step(1, 20, 3, 0, 32'h0, 32'h0, "R10");
        step(0, 0, 0, 0, 32'h0, 32'h0, "R9");
        // R7 pulse over high level, back-to-back pulses
        step(1, 11, 0, 1, 32'h0000_0200, 32'h0, "R7");
        step(1, 5, 3, 0, 32'h0000_0008, 32'h0, "R7");
        step(0, 0, 0, 0, 32'h0, 32'h0, "R9");
        // R6 irq_num held without events
        step(0, 6, 0, 0, 32'h0, 32'h0, "R6");

        for (int i = 0; i < 600; i++) begin
            int s;
            s = ($urandom % 4 == 0) ? int'($urandom % 32) : 5 + int'($urandom % 8);
            step(($urandom % 3) != 0, s, int'($urandom % 4), 1'($urandom),
                 $urandom, $urandom, "R6");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule